// File: doc/BRIEF.md
# Event Queue Producer

This block appends fixed-size event records to a circular queue kept in external memory. Software sets a base address, a log2 queue size and an enable bit, and keeps writing a consumer pointer as it drains entries. The block owns the producer pointer. Each pointer carries the index bits plus one wrap bit directly above them, so a full queue can be told apart from an empty one without spare entries.

When an event record arrives and the queue is enabled and not full, the block computes the entry address, issues one memory write of a whole 32-byte entry and waits for the single response. A good response advances the producer pointer. If the queue held no entries when the event was taken, a one-cycle interrupt pulse follows. Events that arrive while the queue is disabled or full are taken and thrown away, with no memory access. Only one write is in flight at a time, and the event input is held off until it completes.

Top module: `evq_producer`

## Requirements
- R1: After reset, `prod_ptr` is 0, `mem_req` is 0, `irq` is 0 and `evt_ready` is 1.
- R2: An accepted event raises `mem_req` in the following cycle. The write has `mem_addr` = (`cfg_base` with bits [4:0] forced to zero) + 32 × (the index bits of `prod_ptr`), and `mem_data` = the event record.
- R3: The queue is full when the index bits (the low L bits, where L is the effective log2 size) of the two pointers match and their wrap bits (bit L) differ. An event taken while full causes no memory request and leaves `prod_ptr` unchanged.
- R4: An event taken while `cfg_enable` is 0 causes no memory request and leaves `prod_ptr` unchanged.
- R5: A response with `mem_err` = 0 advances `prod_ptr` by one, modulo 2^(L+1), in the cycle after the response. When the index wraps, the wrap bit toggles.
- R6: A response with `mem_err` = 1 leaves `prod_ptr` unchanged and raises no interrupt.
- R7: `irq` is high for exactly one cycle, in the cycle after a good response, if and only if the queue was empty when the event was accepted. Empty means the L+1 low bits of the two pointers are equal.
- R8: From the cycle after an accepted event until the response is seen, `evt_ready` is 0, events are not taken, and `mem_req`, `mem_addr` and `mem_data` hold steady.
- R9: A `cfg_log2size` above MAX_LOG2 (default 8) is treated as MAX_LOG2.
- R10: Bits of `cons_ptr` above bit L do not affect the full or empty decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Queue base address; the low 5 bits are ignored |
| cfg_log2size | input | LOG2_W | log2 of the entry count |
| cfg_enable | input | 1 | Queue enable |
| cons_ptr | input | MAX_LOG2+1 | Consumer pointer (index plus wrap bit), written by software |
| evt_valid | input | 1 | Event record offered |
| evt_ready | output | 1 | Block can take an event |
| evt_data | input | REC_W | Event record |
| mem_req | output | 1 | Memory write request, held until the response |
| mem_addr | output | ADDR_W | Entry write address |
| mem_data | output | REC_W | Entry write data |
| mem_resp | input | 1 | One-cycle write response |
| mem_err | input | 1 | The response reports an error |
| prod_ptr | output | MAX_LOG2+1 | Producer pointer (index plus wrap bit) |
| irq | output | 1 | Pulse: the queue went from empty to non-empty |

## Verification
The bench fills a one-entry queue and a clamped 256-entry queue until they are full. A design that confused full with empty would overwrite unread entries or report an empty queue. Pointer wrap is driven at several sizes, with the garbage bits above bit L of the consumer pointer randomized. A mask of the wrong width would then miss full and empty. Error responses are mixed in, where a wrong design would advance the pointer or pulse the interrupt. The bench also offers events while a write is outstanding, where a design without back-pressure would issue a second request or skip an entry.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } evq_state_t;
endpackage

// File: rtl/evq_ptr_math.sv
module evq_ptr_math #(
  parameter int MAX_LOG2   = 8,
  parameter int LOG2_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int ENTRY_LOG2 = 5
) (
  input  logic [LOG2_W-1:0]   cfg_log2size,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [MAX_LOG2:0]   prod,
  input  logic [MAX_LOG2:0]   cons,
  output logic                full,
  output logic                empty,
  output logic [MAX_LOG2:0]   next_prod,
  output logic [ADDR_W-1:0]   entry_addr
);
  localparam int PW = MAX_LOG2 + 1;
  localparam logic [PW-1:0] PW_ONES = {PW{1'b1}};
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ENTRY_LOG2) - 1);

  logic [LOG2_W-1:0] eff_l;
  logic [LOG2_W-1:0] shamt;
  logic [PW-1:0]     ptr_mask;
  logic [PW-1:0]     idx_mask;
  logic [PW-1:0]     wrap_bit;
  logic [PW-1:0]     diff;
  logic [ADDR_W-1:0] base_al;

  // R9: clamp the size to the largest supported
  always_comb begin
    if (cfg_log2size > LOG2_W'(MAX_LOG2)) eff_l = LOG2_W'(MAX_LOG2);
    else                                   eff_l = cfg_log2size;
    shamt    = LOG2_W'(MAX_LOG2) - eff_l;
    ptr_mask = PW_ONES >> shamt;
    idx_mask = ptr_mask >> 1;
    wrap_bit = PW'(1) << eff_l;
  end

  // R3, R7, R10: compare only the L+1 meaningful bits
  always_comb begin
    diff      = (prod ^ cons) & ptr_mask;
    full      = (diff == wrap_bit);
    empty     = (diff == '0);
    next_prod = (prod + PW'(1)) & ptr_mask;
    base_al   = cfg_base & ~LOW_MASK;
    entry_addr = base_al + (ADDR_W'(prod & idx_mask) << ENTRY_LOG2);
  end

  always_comb begin
    assert_full_empty_excl_R3: assert (!(full && empty));
  end
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int ADDR_W   = 32,
  parameter int REC_W    = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [REC_W-1:0]  evt_data,
  input  logic              q_full,
  input  logic              q_empty,
  input  logic [MAX_LOG2:0] next_prod,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_resp,
  input  logic              mem_err,
  output logic [MAX_LOG2:0] prod_ptr,
  output logic              irq
);
  evq_state_t state;
  logic       was_empty;
  logic       take;
  logic       issue;
  logic       done_ok;

  assign evt_ready = (state == ST_IDLE);
  assign take      = evt_valid && evt_ready;
  assign issue     = take && cfg_enable && !q_full;
  assign done_ok   = (state == ST_WAIT) && mem_resp && !mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      prod_ptr  <= '0;
      irq       <= 1'b0;
      was_empty <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (issue) begin
            mem_req   <= 1'b1;
            was_empty <= q_empty;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_resp) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
            if (!mem_err) begin
              prod_ptr <= next_prod;
              irq      <= was_empty;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // datapath capture, no reset needed
  always_ff @(posedge clk) begin
    if (issue) begin
      mem_addr <= entry_addr;
      mem_data <= evt_data;
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_resp) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
  assert_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !evt_ready);
  assert_prod_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_resp && !mem_err) |=> $stable(prod_ptr));
  assert_irq_after_ok_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_resp && !mem_err));
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_no_drop_req_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_ready && evt_valid && !cfg_enable) |=> !mem_req);
  assert_ok_unused_R5: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> !mem_req);
endmodule

// File: rtl/evq_producer.sv
module evq_producer #(
  parameter int MAX_LOG2   = 8,
  parameter int LOG2_W     = $clog2(MAX_LOG2 + 1),
  parameter int ADDR_W     = 32,
  parameter int ENTRY_LOG2 = 5,
  parameter int REC_W      = 8 << ENTRY_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2size,
  input  logic              cfg_enable,
  input  logic [MAX_LOG2:0] cons_ptr,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [REC_W-1:0]  evt_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_resp,
  input  logic              mem_err,
  output logic [MAX_LOG2:0] prod_ptr,
  output logic              irq
);
  logic              q_full;
  logic              q_empty;
  logic [MAX_LOG2:0] next_prod;
  logic [ADDR_W-1:0] entry_addr;

  evq_ptr_math #(
    .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W), .ADDR_W(ADDR_W), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_math (
    .cfg_log2size(cfg_log2size),
    .cfg_base(cfg_base),
    .prod(prod_ptr),
    .cons(cons_ptr),
    .full(q_full),
    .empty(q_empty),
    .next_prod(next_prod),
    .entry_addr(entry_addr)
  );

  evq_ctrl #(
    .MAX_LOG2(MAX_LOG2), .ADDR_W(ADDR_W), .REC_W(REC_W)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .cfg_enable(cfg_enable),
    .evt_valid(evt_valid),
    .evt_ready(evt_ready),
    .evt_data(evt_data),
    .q_full(q_full),
    .q_empty(q_empty),
    .next_prod(next_prod),
    .entry_addr(entry_addr),
    .mem_req(mem_req),
    .mem_addr(mem_addr),
    .mem_data(mem_data),
    .mem_resp(mem_resp),
    .mem_err(mem_err),
    .prod_ptr(prod_ptr),
    .irq(irq)
  );

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ENTRY_LOG2-1:0] == '0));
endmodule

// File: tb/evq_producer_test.sv
module evq_producer_test;
  localparam int MAX_LOG2 = 8;
  localparam int LOG2_W   = 4;
  localparam int ADDR_W   = 32;
  localparam int REC_W    = 256;
  localparam int PW       = MAX_LOG2 + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] cfg_base = 32'h8000_1234;
  logic [LOG2_W-1:0] cfg_log2size = '0;
  logic              cfg_enable = 1'b0;
  logic [PW-1:0]     cons_ptr = '0;
  logic              evt_valid = 1'b0;
  logic              evt_ready;
  logic [REC_W-1:0]  evt_data = '0;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [REC_W-1:0]  mem_data;
  logic              mem_resp = 1'b0;
  logic              mem_err = 1'b0;
  logic [PW-1:0]     prod_ptr;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [PW-1:0] prod_m;
  logic [PW-1:0] cons_m;

  always #4 clk = ~clk;

  evq_producer #(.MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_log2size(cfg_log2size),
    .cfg_enable(cfg_enable), .cons_ptr(cons_ptr), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_data(evt_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_resp(mem_resp),
    .mem_err(mem_err), .prod_ptr(prod_ptr), .irq(irq));

  function automatic int eff_l();
    return (int'(cfg_log2size) > MAX_LOG2) ? MAX_LOG2 : int'(cfg_log2size);
  endfunction
  function automatic logic [PW-1:0] pmask();
    return PW'((1 << (eff_l() + 1)) - 1);
  endfunction
  function automatic bit m_full();
    int l = eff_l();
    logic [PW-1:0] im = PW'((1 << l) - 1);
    return ((prod_m & im) == (cons_m & im)) && (prod_m[l] != cons_m[l]);
  endfunction
  function automatic bit m_empty();
    return (prod_m & pmask()) == (cons_m & pmask());
  endfunction
  function automatic logic [ADDR_W-1:0] m_addr();
    logic [ADDR_W-1:0] idx = ADDR_W'(prod_m & (pmask() >> 1));
    return {cfg_base[ADDR_W-1:5], 5'b0} + idx * 32;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive_cons();
    logic [PW-1:0] junk = PW'($urandom);
    cons_ptr = (cons_m & pmask()) | (junk & ~pmask()); // R10 garbage upper bits
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    prod_m = '0;
    cons_m = '0;
    drive_cons();
    check("R1 prod", prod_ptr, 0);
    check("R1 req", mem_req, 0);
    check("R1 irq", irq, 0);
    check("R1 ready", evt_ready, 1);
  endtask

  task automatic do_event(bit err, int dly, bit poke);
    logic [REC_W-1:0] d;
    bit full_e, empty_e, drop;
    logic [ADDR_W-1:0] a_e;
    for (int w = 0; w < 8; w++) d[w*32 +: 32] = $urandom;
    full_e  = m_full();
    empty_e = m_empty();
    a_e     = m_addr();
    drop    = !cfg_enable || full_e;
    evt_valid = 1'b1;
    evt_data  = d;
    @(negedge clk);
    evt_valid = 1'b0;
    if (drop) begin
      check(cfg_enable ? "R3 no req when full" : "R4 no req when disabled", mem_req, 0);
      check(cfg_enable ? "R3 prod kept" : "R4 prod kept", prod_ptr, prod_m);
      check("R7 no irq on drop", irq, 0);
      return;
    end
    check("R2 req", mem_req, 1);
    check("R2 addr", mem_addr, a_e);
    check("R2 data", mem_data == d, 1);
    check("R8 ready low", evt_ready, 0);
    for (int k = 0; k < dly; k++) begin
      evt_valid = poke;
      evt_data  = ~d;
      @(negedge clk);
      check("R8 req held", mem_req, 1);
      check("R8 addr held", mem_addr, a_e);
      check("R8 data held", mem_data == d, 1);
    end
    evt_valid = 1'b0;
    mem_resp = 1'b1;
    mem_err  = err;
    @(negedge clk);
    mem_resp = 1'b0;
    mem_err  = 1'b0;
    if (!err) prod_m = (prod_m + 1) & pmask();
    check(err ? "R6 prod kept on error" : "R5 prod advanced", prod_ptr, prod_m);
    check(err ? "R6 no irq on error" : "R7 irq", irq, (!err && empty_e) ? 1 : 0);
    check("R8 single request", mem_req, 0);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
    check("R8 no extra request", mem_req, 0);
  endtask

  task automatic random_phase(int l, int n);
    cfg_log2size = LOG2_W'(l);
    cfg_enable = 1'b1;
    do_reset();
    for (int i = 0; i < n; i++) begin
      cfg_enable = ($urandom % 10) != 0;
      do_event(($urandom % 8) == 0, $urandom % 4, $urandom % 2);
      if (($urandom % 3) == 0) begin
        int occ = int'((prod_m - cons_m) & pmask());
        cons_m = (cons_m + PW'($urandom % (occ + 1))) & pmask();
      end
      drive_cons();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20241));
    @(negedge clk);
    // directed: one-entry queue
    cfg_log2size = 0;
    cfg_enable = 1'b1;
    do_reset();
    do_event(0, 1, 1);                 // R7 empty->non-empty irq, R5
    check("R5 prod=1 on l0", prod_ptr, 9'h001);
    do_event(0, 0, 0);                 // R3 full, dropped
    cons_m = 9'h001; drive_cons(); @(negedge clk);
    do_event(0, 2, 0);                 // R5 wrap back to 0
    check("R5 wrap l0", prod_ptr, 9'h000);
    do_event(1, 0, 0);                 // R6 error (queue full -> dropped)
    cons_m = 9'h000; drive_cons(); @(negedge clk);
    do_event(1, 1, 0);                 // R6 error response
    cfg_enable = 1'b0;
    do_event(0, 0, 0);                 // R4 disabled
    // directed: clamped size fills 256 entries
    cfg_log2size = 4'd12;
    cfg_enable = 1'b1;
    do_reset();
    for (int i = 0; i < 256; i++) do_event(0, 0, 0);
    check("R9 prod after fill", prod_ptr, 9'h100);
    do_event(0, 0, 0);                 // R9 full at 256 entries
    check("R9 full drop", prod_ptr, 9'h100);
    cons_m = 9'h100; drive_cons(); @(negedge clk);
    do_event(0, 0, 0);
    check("R9 index wrap", prod_ptr, 9'h101);
    // random phases
    cfg_base = 32'h0004_0ffd;
    random_phase(1, 150);
    random_phase(3, 150);
    cfg_base = 32'hffff_ff1f;
    random_phase(5, 150);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule